// File: doc/BRIEF.md
# Debug Exception Sequencer

This block sits beside the exception unit of a processor and turns the debug modes that are switched on into an ordered list of debug exceptions for each retiring instruction. An address breakpoint, branch trace and single-step can all be on at once. The block applies one fixed ordering: the breakpoint is taken first, and then one trace exception follows it. Branch trace and single-step give the same trace exception. When both of them apply, they merge into one trace action and never into two.

For each instruction that retires while no action is outstanding, the block presents a first action code on `act_code`. It keeps any second action in a one-deep queue and signals this on `act_more`. Each action stays on the output until the exception unit pulses `ack`. On the cycle after that acknowledge, the block shows the queued action, or returns to idle if there is none. While any action is outstanding, the block does not look at new retiring instructions.

Top module: `dbg_seq_ctl`

## Requirements
- R1: After reset, `act_code` is 00 and `act_more` is 0.
- R2: `act_code` uses 00 for no action, 01 for address breakpoint and 10 for trace. The value 11 never appears.
- R3: If the breakpoint is enabled and matched and branch trace is on for a branch, the block presents 01 with `act_more`=1, and then 10 with `act_more`=0.
- R4: If the breakpoint is enabled and matched and single-step is on, the block presents 01 with `act_more`=1, and then 10 with `act_more`=0.
- R5: If branch trace and single-step are both on, with no breakpoint, and the instruction is a branch, the block presents exactly one 10 action with `act_more`=0.
- R6: If all three modes are on and the breakpoint matches on a branch, the block presents 01, then one single 10, then 00.
- R7: Branch trace applies only when `is_branch` is 1. Single-step applies to every retiring instruction. If neither trace nor a breakpoint applies, the output stays 00.
- R8: If the breakpoint is enabled but `brk_hit` is 0, the breakpoint step is skipped, and any trace that applies becomes the first action, shown as 10 with `act_more`=0.
- R9: A presented action stays on the output until `ack` is sampled high. On the cycle after that acknowledge, the queued action appears, or 00 if nothing is queued.
- R10: A `retire_vld` pulse while `act_code` is not 00 is ignored and adds no action.
- R11: A matched breakpoint with no trace applying presents 01 with `act_more`=0, and returns to 00 after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_vld | input | 1 | An instruction retires this cycle |
| brk_en | input | 1 | Address breakpoint enabled |
| brk_hit | input | 1 | Retiring address matches the breakpoint |
| btrace_en | input | 1 | Branch trace enabled |
| sstep_en | input | 1 | Single-step enabled |
| is_branch | input | 1 | Retiring instruction is a branch |
| ack | input | 1 | Exception unit has taken the presented action |
| act_code | output | 2 | Presented action: 00 none, 01 breakpoint, 10 trace |
| act_more | output | 1 | A second action is queued behind the presented one |

## Verification
The sequencing is tried with every overlap of the modes. A breakpoint is paired with branch trace, then with single-step, then with both. Two-trace cases are run with no breakpoint. These runs show the two-step ordering apart from the merge of the two trace modes into one. Each mode is also run alone, on branch and non-branch instructions, and with the breakpoint enabled but not matched. These runs show the branch qualifier and the skipped breakpoint step apart from a plain trace. The acknowledge is held back for several cycles so that the output must hold steady. A second retire pulse is sent while an action is outstanding, to show that it is dropped.

// File: rtl/dbg_seq_ctl.sv
module dbg_seq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       retire_vld,
  input  logic       brk_en,
  input  logic       brk_hit,
  input  logic       btrace_en,
  input  logic       sstep_en,
  input  logic       is_branch,
  input  logic       ack,
  output logic [1:0] act_code,
  output logic       act_more
);

  localparam logic [1:0] ACT_NONE = 2'b00;
  localparam logic [1:0] ACT_BRK  = 2'b01;
  localparam logic [1:0] ACT_TRC  = 2'b10;

  logic [1:0] cur_q, nxt_q;
  logic       idle, bp_fire, tr_fire;
  logic [1:0] first_c, second_c;

  assign idle     = (cur_q == ACT_NONE);
  assign bp_fire  = brk_en & brk_hit;
  assign tr_fire  = sstep_en | (btrace_en & is_branch);
  assign first_c  = bp_fire ? ACT_BRK : (tr_fire ? ACT_TRC : ACT_NONE);
  assign second_c = (bp_fire & tr_fire) ? ACT_TRC : ACT_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= ACT_NONE;
      nxt_q <= ACT_NONE;
    end else if (idle) begin
      if (retire_vld) begin
        cur_q <= first_c;
        nxt_q <= second_c;
      end
    end else if (ack) begin
      cur_q <= nxt_q;
      nxt_q <= ACT_NONE;
    end
  end

  assign act_code = cur_q;
  assign act_more = (nxt_q != ACT_NONE);

endmodule

// File: rtl/dbg_seq_ctl_chk.sv
module dbg_seq_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       retire_vld,
  input logic       brk_en,
  input logic       brk_hit,
  input logic       btrace_en,
  input logic       sstep_en,
  input logic       is_branch,
  input logic       ack,
  input logic [1:0] act_code,
  input logic       act_more
);

  logic take, bp, tr;
  assign take = retire_vld && (act_code == 2'b00);
  assign bp   = brk_en && brk_hit;
  assign tr   = sstep_en || (btrace_en && is_branch);

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_code != 2'b11);

  p_brk_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && bp |=> act_code == 2'b01);

  p_pair_queued_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && bp && tr |=> act_more);

  p_trace_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bp && tr |=> act_code == 2'b10 && !act_more);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bp && !tr |=> act_code == 2'b00);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_code != 2'b00 && !ack |=> $stable(act_code) && $stable(act_more));

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_code != 2'b00 && ack && act_more |=> act_code == 2'b10 && !act_more);

  p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    act_code != 2'b00 && ack && !act_more |=> act_code == 2'b00);

  p_more_after_brk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_more |-> act_code == 2'b01);

endmodule

bind dbg_seq_ctl dbg_seq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .brk_en(brk_en),
  .brk_hit(brk_hit), .btrace_en(btrace_en), .sstep_en(sstep_en),
  .is_branch(is_branch), .ack(ack), .act_code(act_code), .act_more(act_more)
);

// File: tb/tb_dbg_seq_ctl.sv
`timescale 1ns/1ps
module tb_dbg_seq_ctl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_vld = 1'b0, brk_en = 1'b0, brk_hit = 1'b0;
  logic btrace_en = 1'b0, sstep_en = 1'b0, is_branch = 1'b0, ack = 1'b0;
  logic [1:0] act_code;
  logic act_more;

  always #2 clk = ~clk;

  dbg_seq_ctl dut (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .brk_en(brk_en),
    .brk_hit(brk_hit), .btrace_en(btrace_en), .sstep_en(sstep_en),
    .is_branch(is_branch), .ack(ack), .act_code(act_code), .act_more(act_more)
  );

  typedef struct {
    logic [1:0] code;
    logic       more;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic m, input string r);
    exp_t e;
    e.code = c; e.more = m; e.req = r;
    q.push_back(e);
  endtask

  task automatic retire(input logic be, input logic bh, input logic bt,
                        input logic ss, input logic br, input string req);
    logic bp, tr;
    bp = be & bh;
    tr = ss | (bt & br);
    @(negedge clk);
    brk_en = be; brk_hit = bh; btrace_en = bt; sstep_en = ss; is_branch = br;
    retire_vld = 1'b1;
    if (bp) begin
      push(2'b01, tr, req);
      if (tr) push(2'b10, 1'b0, req);
    end else if (tr) begin
      push(2'b10, 1'b0, req);
    end
    @(negedge clk);
    retire_vld = 1'b0;
  endtask

  task automatic settle(input string req);
    while (q.size() != 0 || act_code != 2'b00) @(negedge clk);
    repeat (3) @(negedge clk);
    check(act_code == 2'b00, req, act_code, 0);
  endtask

  // monitor: pop expected actions, hold, then acknowledge
  initial begin
    forever begin
      @(negedge clk);
      ack = 1'b0;
      if (rst_n && act_code != 2'b00) begin
        exp_t e;
        check(act_code != 2'b11, "R2", act_code, 0);
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected action", act_code, 0);
        end else begin
          logic [1:0] seen;
          e = q.pop_front();
          seen = act_code;
          check(act_code == e.code, e.req, act_code, e.code);
          check(act_more == e.more, {e.req, " more"}, act_more, e.more);
          repeat (2) begin
            @(negedge clk);
            check(act_code == seen, "R9 hold", act_code, seen);
          end
        end
        ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(act_code == 2'b00, "R1 code", act_code, 0);
    check(act_more == 1'b0, "R1 more", act_more, 0);
    rst_n = 1'b1;
    @(negedge clk);

    retire(1, 1, 1, 0, 1, "R3");  settle("R3 end");
    retire(1, 1, 0, 1, 0, "R4");  settle("R4 end");
    retire(0, 0, 1, 1, 1, "R5");  settle("R5 end");
    retire(1, 1, 1, 1, 1, "R6");  settle("R6 end");
    retire(1, 0, 0, 1, 0, "R8");  settle("R8 end");
    retire(1, 0, 1, 0, 1, "R8");  settle("R8 end");
    retire(1, 1, 0, 0, 0, "R11"); settle("R11 end");
    retire(1, 1, 1, 0, 0, "R7");  settle("R7 end");
    retire(0, 0, 0, 1, 0, "R7");  settle("R7 end");
    retire(0, 0, 1, 0, 0, "R7");  settle("R7 quiet");
    retire(0, 1, 0, 0, 1, "R7");  settle("R7 quiet");

    // R10: second retire while first action still presented
    retire(1, 1, 0, 1, 1, "R10");
    @(negedge clk);
    brk_en = 1'b0; brk_hit = 1'b0; btrace_en = 1'b1; sstep_en = 1'b1; is_branch = 1'b1;
    retire_vld = 1'b1;
    @(negedge clk);
    retire_vld = 1'b0;
    settle("R10 dropped");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule